// File: doc/BRIEF.md
# Protected Code Region Access Guard

This block stands between the bus masters of a small processor system and one contiguous memory region that holds protected code and its private data. Data inside the region can be read or written only by instructions that were themselves fetched from inside the region. A debug port, a boot loader or a DMA engine that reads the region sees a fixed masking word instead of the stored contents. CPU code running outside the region may still branch or call into it, because instruction fetches into the region are always let through. The guard remembers whether the most recent CPU instruction fetch landed inside the region, and it judges every following CPU data access by that flag.

The region is not set by software. After a brown-out reset, a boot sequencer keeps the CPU held in reset and reads a signature word from a fixed address. When the signature matches, it reads a pointer word and then fetches a four-word configuration structure from the address that pointer gives. It enables protection only when the structure's check word is consistent with the other three words. A lock bit in the structure keeps the loaded configuration through warm resets. Only a brown-out reset clears it.

Access violations are reported in two ways. There is a pulse in the cycle of the offending access, and there is a sticky flag that stays set until the next brown-out reset. A violating write never reaches the memory, and a violating read returns the masking word.

Top module: `code_vault_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cpu_hold` is 1 and protection is off: no access is masked or flagged.
- R2: The sequencer first reads the signature word at 0xFF88. If that word is not 0xAAAA, `cpu_hold` is high for exactly one cycle after reset, protection stays off, and nothing else is read.
- R3: With a valid signature, the sequencer reads 0xFF88, then 0xFF8A, then the four words at B, B+2, B+4 and B+6, one per cycle. B is the word read at 0xFF8A shifted left by four bits. `cpu_hold` is high for exactly six cycles after reset.
- R4: The four structure words are control, upper border and lower border, then a check word, in that address order. The configuration is applied only when check == control ^ upper ^ lower ^ 0xFFFF. Otherwise protection stays off.
- R5: Control bit 0 enables protection and control bit 1 locks it. A border word holds an address shifted right by four. The protected region is lower<<4 <= address < upper<<4.
- R6: A non-CPU access (`acc_cpu`=0) into the enabled region is a violation. A read of this kind returns 0x3FFF, and a write of this kind is dropped.
- R7: A CPU instruction fetch (`acc_kind`=2'b00) is never a violation. Each CPU fetch sets the last-fetch flag to whether its address is inside the region, and the flag takes that value from the next cycle on.
- R8: A CPU data access (`acc_kind` 2'b01 or 2'b11 for reads, 2'b10 for writes) into the region is allowed only when the last-fetch flag is set. A disallowed CPU read returns 0x3FFF, a disallowed CPU write is dropped, and `viol` pulses.
- R9: An access outside the region, or any access while protection is off, passes through: `acc_rdata` equals `mem_rdata`, a write reaches `mem_we`, and `viol` stays 0.
- R10: `viol_sticky` rises in the cycle after any violation. It holds through warm resets and clears only on a brown-out reset.
- R11: A warm reset always clears the last-fetch flag. If the lock bit is set, the configuration is kept and `cpu_hold` stays low. If the lock bit is clear, protection is dropped and the whole boot load runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Brown-out reset, active low, asynchronous |
| warm_rst | input | 1 | Warm reset request, synchronous, one cycle |
| cpu_hold | output | 1 | Holds the CPU in reset while the boot load runs |
| boot_rd | output | 1 | Boot sequencer read strobe |
| boot_addr | output | 16 | Boot sequencer read address |
| boot_rdata | input | 16 | Word at `boot_addr`, same cycle |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_cpu | input | 1 | 1 = access from the CPU, 0 = debug, loader or DMA |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| acc_addr | input | 16 | Byte address of the access |
| mem_rdata | input | 16 | Read data from the memory array |
| acc_rdata | output | 16 | Read data returned to the master, masked if denied |
| mem_we | output | 1 | Write enable to the memory array |
| viol | output | 1 | Violation in this cycle |
| viol_sticky | output | 1 | Sticky violation flag |

## Verification
The embedded properties check these rules on every cycle:
- A denied non-CPU read always returns the masking word.
- A CPU fetch is never flagged.
- Out-of-region traffic always passes through.
- A violation always sets the sticky flag on the next cycle.
- A wrong signature ends the load at once.
- A finished load stays finished.
- A locked configuration never moves.

The following behaviour depends on memory contents and on the order of accesses, so only the bench scenarios can show it:
- The exact six-cycle read order.
- The rejection of a structure with a bad check word.
- The region edges.
- A data read that is allowed only after a fetch from inside the region.
- A warm reset that reruns the load when the configuration is unlocked, and keeps it when locked.

// File: rtl/cvg_pkg.sv
package cvg_pkg;

    // Boot sequencer phases, one memory word read per phase.
    typedef enum logic [2:0] {
        BS_SIG  = 3'd0,
        BS_PTR  = 3'd1,
        BS_CTL  = 3'd2,
        BS_UPP  = 3'd3,
        BS_LOW  = 3'd4,
        BS_CHK  = 3'd5,
        BS_DONE = 3'd6
    } boot_state_e;

    // Access kinds presented on the guarded port.
    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_READ2 = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/cvg_boot_seq.sv
module cvg_boot_seq
    import cvg_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int GRAN_SHIFT = 4,
    parameter logic [AW-1:0] SIG_ADDR  = 16'hFF88,
    parameter logic [AW-1:0] PTR_ADDR  = 16'hFF8A,
    parameter logic [DW-1:0] SIG_VALUE = 16'hAAAA,
    parameter int EN_BIT     = 0,
    parameter int LOCK_BIT   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     warm_rst,
    input  logic [DW-1:0]            boot_rdata,
    output logic                     boot_rd,
    output logic [AW-1:0]            boot_addr,
    output logic                     busy,
    output logic                     prot_en,
    output logic [AW-GRAN_SHIFT-1:0] bnd_lo,
    output logic [AW-GRAN_SHIFT-1:0] bnd_hi
);
    localparam int BW    = AW - GRAN_SHIFT;
    localparam int WSTEP = DW / 8;

    typedef struct packed {
        boot_state_e      st;
        logic [BW-1:0]    ptr;
        logic [DW-1:0]    ctl;
        logic [DW-1:0]    upp;
        logic [DW-1:0]    low;
        logic             en;
        logic             lock;
        logic [BW-1:0]    lo;
        logic [BW-1:0]    hi;
    } seq_t;

    seq_t s_d, s_q;
    logic [AW-1:0] base;

    always_comb begin
        s_d       = s_q;
        boot_rd   = 1'b0;
        boot_addr = '0;
        base      = {s_q.ptr, {GRAN_SHIFT{1'b0}}};
        case (s_q.st)
            BS_SIG: begin
                boot_rd   = 1'b1;
                boot_addr = SIG_ADDR;
                s_d.st    = (boot_rdata == SIG_VALUE) ? BS_PTR : BS_DONE;
            end
            BS_PTR: begin
                boot_rd   = 1'b1;
                boot_addr = PTR_ADDR;
                s_d.ptr   = boot_rdata[BW-1:0];
                s_d.st    = BS_CTL;
            end
            BS_CTL: begin
                boot_rd   = 1'b1;
                boot_addr = base;
                s_d.ctl   = boot_rdata;
                s_d.st    = BS_UPP;
            end
            BS_UPP: begin
                boot_rd   = 1'b1;
                boot_addr = base + AW'(WSTEP);
                s_d.upp   = boot_rdata;
                s_d.st    = BS_LOW;
            end
            BS_LOW: begin
                boot_rd   = 1'b1;
                boot_addr = base + AW'(2 * WSTEP);
                s_d.low   = boot_rdata;
                s_d.st    = BS_CHK;
            end
            BS_CHK: begin
                boot_rd   = 1'b1;
                boot_addr = base + AW'(3 * WSTEP);
                if (boot_rdata == (s_q.ctl ^ s_q.upp ^ s_q.low ^ {DW{1'b1}})) begin
                    s_d.en   = s_q.ctl[EN_BIT];
                    s_d.lock = s_q.ctl[LOCK_BIT];
                    s_d.lo   = s_q.low[BW-1:0];
                    s_d.hi   = s_q.upp[BW-1:0];
                end
                s_d.st    = BS_DONE;
            end
            default: begin
                s_d.st    = BS_DONE;
            end
        endcase
        // Warm reset reruns the load unless the configuration is locked.
        if (warm_rst && !s_q.lock) begin
            s_d    = '0;
            s_d.st = BS_SIG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
        end else begin
            s_q    <= s_d;
        end
    end

    assign busy    = (s_q.st != BS_DONE);
    assign prot_en = s_q.en;
    assign bnd_lo  = s_q.lo;
    assign bnd_hi  = s_q.hi;

    // R2: a wrong signature ends the load with protection off.
    assert_bad_sig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == BS_SIG && boot_rdata != SIG_VALUE && !warm_rst)
        |=> (s_q.st == BS_DONE && !s_q.en));

    // R3: a finished load stays finished unless an unlocked warm reset restarts it.
    assert_done_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == BS_DONE && !(warm_rst && !s_q.lock)) |=> (s_q.st == BS_DONE));

    // R11: a locked configuration never changes.
    assert_locked_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lock && s_q.st == BS_DONE) |=> ($stable({s_q.en, s_q.lo, s_q.hi}) && s_q.lock));

endmodule

// File: rtl/cvg_region_cmp.sv
module cvg_region_cmp #(
    parameter int AW         = 16,
    parameter int GRAN_SHIFT = 4
) (
    input  logic                     prot_en,
    input  logic [AW-GRAN_SHIFT-1:0] bnd_lo,
    input  logic [AW-GRAN_SHIFT-1:0] bnd_hi,
    input  logic [AW-1:0]            addr,
    output logic                     hit
);
    logic [AW-1:0] lo_addr;
    logic [AW-1:0] hi_addr;

    always_comb begin
        lo_addr = {bnd_lo, {GRAN_SHIFT{1'b0}}};
        hi_addr = {bnd_hi, {GRAN_SHIFT{1'b0}}};
        // Lower border inclusive, upper border exclusive.
        hit     = prot_en && (addr >= lo_addr) && (addr < hi_addr);
    end
endmodule

// File: rtl/cvg_access_ctl.sv
module cvg_access_ctl
    import cvg_pkg::*;
#(
    parameter int DW = 16,
    parameter logic [DW-1:0] MASK_VALUE = 16'h3FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          hit,
    input  logic          acc_valid,
    input  logic          acc_cpu,
    input  logic [1:0]    acc_kind,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_rdata,
    output logic          mem_we,
    output logic          viol,
    output logic          viol_sticky
);
    typedef struct packed {
        logic last_in;
        logic sticky;
    } trk_t;

    trk_t      t_d, t_q;
    acc_kind_e kind;
    logic      is_write;
    logic      is_fetch;
    logic      allowed;

    always_comb begin
        kind      = acc_kind_e'(acc_kind);
        is_write  = (kind == KIND_WRITE);
        is_fetch  = acc_cpu && (kind == KIND_FETCH);
        allowed   = !hit || (acc_cpu && (is_fetch || t_q.last_in));
        viol      = acc_valid && !allowed;
        mem_we    = acc_valid && is_write && allowed;
        acc_rdata = (acc_valid && !is_write && !allowed) ? MASK_VALUE : mem_rdata;

        t_d        = t_q;
        t_d.sticky = t_q.sticky | viol;
        if (warm_rst) begin
            t_d.last_in = 1'b0;
        end else if (acc_valid && is_fetch) begin
            t_d.last_in = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign viol_sticky = t_q.sticky;

    // R6: denied non-CPU read returns the masking word.
    assert_mask_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_cpu && hit && acc_kind != 2'b10) |-> (acc_rdata == MASK_VALUE));

    // R7: CPU instruction fetch is never a violation.
    assert_fetch_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_cpu && acc_kind == 2'b00) |-> !viol);

    // R9: outside the region everything passes through.
    assert_outside_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !hit) |-> (!viol && acc_rdata == mem_rdata));

    // R10: a violation sets the sticky flag next cycle.
    assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol_sticky);

endmodule

// File: rtl/code_vault_guard.sv
module code_vault_guard #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int GRAN_SHIFT = 4,
    parameter logic [AW-1:0] SIG_ADDR   = 16'hFF88,
    parameter logic [AW-1:0] PTR_ADDR   = 16'hFF8A,
    parameter logic [DW-1:0] SIG_VALUE  = 16'hAAAA,
    parameter logic [DW-1:0] MASK_VALUE = 16'h3FFF,
    parameter int EN_BIT     = 0,
    parameter int LOCK_BIT   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    output logic          cpu_hold,
    output logic          boot_rd,
    output logic [AW-1:0] boot_addr,
    input  logic [DW-1:0] boot_rdata,
    input  logic          acc_valid,
    input  logic          acc_cpu,
    input  logic [1:0]    acc_kind,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_rdata,
    output logic          mem_we,
    output logic          viol,
    output logic          viol_sticky
);
    localparam int BW = AW - GRAN_SHIFT;

    logic          prot_en;
    logic [BW-1:0] bnd_lo;
    logic [BW-1:0] bnd_hi;
    logic          hit;

    cvg_boot_seq #(
        .AW(AW), .DW(DW), .GRAN_SHIFT(GRAN_SHIFT),
        .SIG_ADDR(SIG_ADDR), .PTR_ADDR(PTR_ADDR), .SIG_VALUE(SIG_VALUE),
        .EN_BIT(EN_BIT), .LOCK_BIT(LOCK_BIT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .boot_rdata(boot_rdata), .boot_rd(boot_rd), .boot_addr(boot_addr),
        .busy(cpu_hold), .prot_en(prot_en), .bnd_lo(bnd_lo), .bnd_hi(bnd_hi)
    );

    cvg_region_cmp #(.AW(AW), .GRAN_SHIFT(GRAN_SHIFT)) u_cmp (
        .prot_en(prot_en), .bnd_lo(bnd_lo), .bnd_hi(bnd_hi),
        .addr(acc_addr), .hit(hit)
    );

    cvg_access_ctl #(.DW(DW), .MASK_VALUE(MASK_VALUE)) u_acc (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .hit(hit),
        .acc_valid(acc_valid), .acc_cpu(acc_cpu), .acc_kind(acc_kind),
        .mem_rdata(mem_rdata), .acc_rdata(acc_rdata), .mem_we(mem_we),
        .viol(viol), .viol_sticky(viol_sticky)
    );

    // R1: no masking or flagging while the load is running.
    assert_hold_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |-> (!viol && acc_rdata == mem_rdata));

endmodule

// File: tb/code_vault_guard_test.sv
module code_vault_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        cpu_hold, boot_rd, mem_we, viol, viol_sticky;
    logic [15:0] boot_addr, boot_rdata, acc_rdata;
    logic        acc_valid = 1'b0, acc_cpu = 1'b0;
    logic [1:0]  acc_kind = 2'b01;
    logic [15:0] acc_addr = 16'h0000;
    logic [15:0] mem_rdata;

    int checks = 0;
    int errors = 0;

    // Boot memory contents driven by the scenarios.
    logic [15:0] sig_w, ptr_w, w_ctl, w_upp, w_low, w_chk;

    always #10 clk = ~clk;

    code_vault_guard uut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .cpu_hold(cpu_hold),
        .boot_rd(boot_rd), .boot_addr(boot_addr), .boot_rdata(boot_rdata),
        .acc_valid(acc_valid), .acc_cpu(acc_cpu), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .mem_rdata(mem_rdata), .acc_rdata(acc_rdata),
        .mem_we(mem_we), .viol(viol), .viol_sticky(viol_sticky)
    );

    assign mem_rdata = acc_addr ^ 16'hA5C3;

    always_comb begin
        boot_rdata = 16'h0000;
        if (boot_addr == 16'hFF88) boot_rdata = sig_w;
        else if (boot_addr == 16'hFF8A) boot_rdata = ptr_w;
        else if (boot_addr == {ptr_w[11:0], 4'h0}) boot_rdata = w_ctl;
        else if (boot_addr == {ptr_w[11:0], 4'h0} + 16'd2) boot_rdata = w_upp;
        else if (boot_addr == {ptr_w[11:0], 4'h0} + 16'd4) boot_rdata = w_low;
        else if (boot_addr == {ptr_w[11:0], 4'h0} + 16'd6) boot_rdata = w_chk;
    end

    // ---------------- behavioural reference model ----------------
    int          hold_left;
    bit          m_sigok, m_en, m_lock, m_last, m_sticky, p_en, p_lock;
    logic [11:0] m_lo, m_hi, p_lo, p_hi;
    logic [15:0] m_base;

    task automatic plan_boot();
        bit ok;
        m_sigok   = (sig_w == 16'hAAAA);
        m_base    = {ptr_w[11:0], 4'h0};
        hold_left = m_sigok ? 6 : 1;
        ok        = m_sigok && (w_chk == (w_ctl ^ w_upp ^ w_low ^ 16'hFFFF));
        p_en      = ok && w_ctl[0];
        p_lock    = ok && w_ctl[1];
        p_lo      = w_low[11:0];
        p_hi      = w_upp[11:0];
        m_en      = 1'b0;
        m_lock    = 1'b0;
        m_lo      = 12'h0;
        m_hi      = 12'h0;
    endtask

    function automatic bit m_hit(input logic [15:0] a);
        return m_en && (a >= {m_lo, 4'h0}) && (a < {m_hi, 4'h0});
    endfunction

    function automatic bit m_allowed();
        return !m_hit(acc_addr) || (acc_cpu && (acc_kind == 2'b00 || m_last));
    endfunction

    function automatic logic [15:0] m_boot_addr();
        case (hold_left)
            6: return 16'hFF88;
            5: return 16'hFF8A;
            4: return m_base;
            3: return m_base + 16'd2;
            2: return m_base + 16'd4;
            1: return m_sigok ? m_base + 16'd6 : 16'hFF88;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plan_boot();
            m_last   = 1'b0;
            m_sticky = 1'b0;
        end else begin
            bit old_lock;
            old_lock = m_lock;
            if (acc_valid && !m_allowed()) m_sticky = 1'b1;
            if (acc_valid && acc_cpu && acc_kind == 2'b00) m_last = m_hit(acc_addr);
            if (hold_left > 0) begin
                hold_left--;
                if (hold_left == 0) begin
                    m_en = p_en; m_lock = p_lock; m_lo = p_lo; m_hi = p_hi;
                end
            end
            if (warm_rst) begin
                m_last = 1'b0;
                if (!old_lock) plan_boot();
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        bit        e_deny, e_wr;
        e_deny = acc_valid && !m_allowed();
        e_wr   = (acc_kind == 2'b10);
        chk(cpu_hold == (hold_left > 0), "R3 cpu_hold", 16'(cpu_hold), 16'(hold_left > 0));
        chk(boot_rd == (hold_left > 0), "R3 boot_rd", 16'(boot_rd), 16'(hold_left > 0));
        if (hold_left > 0)
            chk(boot_addr == m_boot_addr(), "R3 boot_addr", boot_addr, m_boot_addr());
        chk(viol == e_deny, "R8 viol", 16'(viol), 16'(e_deny));
        chk(mem_we == (acc_valid && e_wr && !e_deny), "R8 mem_we", 16'(mem_we),
            16'(acc_valid && e_wr && !e_deny));
        chk(acc_rdata == ((e_deny && !e_wr) ? 16'h3FFF : mem_rdata), "R8 acc_rdata", acc_rdata,
            (e_deny && !e_wr) ? 16'h3FFF : mem_rdata);
        chk(viol_sticky == m_sticky, "R10 viol_sticky", 16'(viol_sticky), 16'(m_sticky));
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_boot(input logic [15:0] sig, input logic [15:0] ctl,
                            input logic [15:0] upp, input logic [15:0] low, input bit good_chk);
        sig_w = sig; ptr_w = 16'h0F00;
        w_ctl = ctl; w_upp = upp; w_low = low;
        w_chk = good_chk ? (ctl ^ upp ^ low ^ 16'hFFFF) : (ctl ^ upp ^ low);
    endtask

    task automatic count_hold(input string tag, input int expn);
        int n = 0;
        @(negedge clk);
        while (cpu_hold && n < 20) begin
            n++;
            @(negedge clk);
        end
        chk(n == expn, tag, 16'(n), 16'(expn));
    endtask

    task automatic brownout(input string tag, input int expn);
        @(posedge clk); #2 rst_n = 1'b0;
        @(negedge clk);
        chk(cpu_hold == 1'b1, "R1 hold in reset", 16'(cpu_hold), 16'h1);
        @(posedge clk); #2 rst_n = 1'b1;
        count_hold(tag, expn);
    endtask

    task automatic warm(input string tag, input int expn);
        @(posedge clk); #2 warm_rst = 1'b1;
        @(posedge clk); #2 warm_rst = 1'b0;
        count_hold(tag, expn);
    endtask

    task automatic access(input bit cpu, input logic [1:0] kind, input logic [15:0] a,
                          input string tag, input logic [15:0] e_rd, input bit e_we, input bit e_v);
        @(posedge clk); #2;
        acc_valid = 1'b1; acc_cpu = cpu; acc_kind = kind; acc_addr = a;
        @(negedge clk);
        if (kind != 2'b10) chk(acc_rdata == e_rd, {tag, " rdata"}, acc_rdata, e_rd);
        chk(mem_we == e_we, {tag, " we"}, 16'(mem_we), 16'(e_we));
        chk(viol == e_v, {tag, " viol"}, 16'(viol), 16'(e_v));
        @(posedge clk); #2 acc_valid = 1'b0;
    endtask

    function automatic logic [15:0] md(input logic [15:0] a);
        return a ^ 16'hA5C3;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // A: enabled and locked region 0x4400..0x47FF
        set_boot(16'hAAAA, 16'h0003, 16'h0480, 16'h0440, 1'b1);
        brownout("R3 hold six cycles", 6);
        access(1'b0, 2'b01, 16'h4500, "R6 dbg read masked", 16'h3FFF, 1'b0, 1'b1);
        access(1'b0, 2'b10, 16'h4600, "R6 dma write dropped", 16'h0, 1'b0, 1'b1);
        access(1'b0, 2'b01, 16'h3000, "R9 outside read", md(16'h3000), 1'b0, 1'b0);
        access(1'b0, 2'b10, 16'h3000, "R9 outside write", 16'h0, 1'b1, 1'b0);
        access(1'b1, 2'b00, 16'h1000, "R7 fetch outside", md(16'h1000), 1'b0, 1'b0);
        access(1'b1, 2'b01, 16'h4500, "R8 cpu read from outside code", 16'h3FFF, 1'b0, 1'b1);
        access(1'b1, 2'b10, 16'h4500, "R8 cpu write from outside code", 16'h0, 1'b0, 1'b1);
        chk(viol_sticky == 1'b1, "R10 sticky set", 16'(viol_sticky), 16'h1);
        access(1'b1, 2'b00, 16'h4400, "R7 fetch into region", md(16'h4400), 1'b0, 1'b0);
        access(1'b1, 2'b11, 16'h47FE, "R8 cpu read inside", md(16'h47FE), 1'b0, 1'b0);
        access(1'b1, 2'b10, 16'h4400, "R8 cpu write inside", 16'h0, 1'b1, 1'b0);
        access(1'b0, 2'b01, 16'h43FE, "R5 below lower", md(16'h43FE), 1'b0, 1'b0);
        access(1'b0, 2'b01, 16'h4800, "R5 upper exclusive", md(16'h4800), 1'b0, 1'b0);
        access(1'b0, 2'b01, 16'h4400, "R5 lower inclusive", 16'h3FFF, 1'b0, 1'b1);
        warm("R11 locked warm keeps config", 0);
        access(1'b1, 2'b01, 16'h4500, "R11 warm clears last fetch", 16'h3FFF, 1'b0, 1'b1);
        chk(viol_sticky == 1'b1, "R10 sticky across warm", 16'(viol_sticky), 16'h1);
        // B: bad check word
        set_boot(16'hAAAA, 16'h0003, 16'h0480, 16'h0440, 1'b0);
        brownout("R4 hold with bad check", 6);
        chk(viol_sticky == 1'b0, "R10 cleared by brown-out", 16'(viol_sticky), 16'h0);
        access(1'b0, 2'b01, 16'h4500, "R4 bad check no protection", md(16'h4500), 1'b0, 1'b0);
        // C: bad signature
        set_boot(16'h5555, 16'h0003, 16'h0480, 16'h0440, 1'b1);
        brownout("R2 one cycle hold", 1);
        access(1'b0, 2'b01, 16'h4500, "R2 no protection", md(16'h4500), 1'b0, 1'b0);
        // D: enabled, unlocked; warm reset reloads
        set_boot(16'hAAAA, 16'h0001, 16'h0480, 16'h0440, 1'b1);
        brownout("R3 hold unlocked", 6);
        access(1'b0, 2'b01, 16'h4500, "R5 enable bit", 16'h3FFF, 1'b0, 1'b1);
        sig_w = 16'h1234;
        warm("R11 unlocked warm reruns load", 1);
        access(1'b0, 2'b01, 16'h4500, "R11 reload dropped protection", md(16'h4500), 1'b0, 1'b0);
        // E: lock without enable
        set_boot(16'hAAAA, 16'h0002, 16'h0480, 16'h0440, 1'b1);
        brownout("R3 hold lock only", 6);
        access(1'b0, 2'b01, 16'h4500, "R5 enable clear", md(16'h4500), 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule